// File: doc/BRIEF.md
# Frame word packer with length and timestamp trailer

This block builds the final 32-bit word stream of one compressed image frame. Two sources feed it. In compressed mode, partially filled words arrive, each with a count of its valid leading bytes. In raw mode, uncompressed bytes arrive one per clock in groups of four. Both sources are packed densely into whole output words. The block counts every payload byte it accepts. When a flush is requested it pads any partial word with zeros and then closes the frame with a trailer: the payload length word followed by two timestamp words.

The timestamp is written byte by byte in a separate system clock domain. A copy request issued in the pixel clock domain moves it across. In compressed mode the request is raised at the end of the first colour period of a frame; in raw mode it is raised explicitly before flushing. The crossing uses a toggle request and a toggle acknowledge, and the source keeps the 64-bit value stable until the acknowledge returns. A start pulse raises the running flag. Done rises a fixed number of cycles after the last trailer word. Done stays high until the block is disabled, and is held low while the enable input is low. An abort input returns the block to its accepting state and emits nothing.

Top module: `frame_word_packer`

## Requirements
- R1: In compressed mode, `cmp_bytes` gives the number of valid bytes, taken from the most significant end of `cmp_data`; the value 0 means all four are valid. Accepted bytes fill output words from the most significant byte down. A word is output with `out_valid` in the cycle after the clock edge that completes it.
- R2: In raw mode, a `raw_pre` pulse is followed by four bytes on `raw_byte`, one per cycle. The bytes form one word with the first byte in bits 31:24. That word appears one cycle later than a compressed word would.
- R3: With `raw_swap` high, each pair of raw bytes is exchanged, so bytes b0 b1 b2 b3 produce the word {b1,b0,b3,b2}.
- R4: One cycle after `ts_pre`, eight timestamp bytes arrive on `ts_byte`: four seconds bytes, then four microseconds bytes. The first timestamp trailer word carries bytes 0 to 3, and the second carries bytes 4 to 7, each with the earlier byte in the higher position.
- R5: `ts_copy` moves the last loaded timestamp into the pixel domain. A flush requested while a copy is still in progress waits for the copy to finish. Bytes loaded after a completed copy do not reach the trailer.
- R6: After a flush, a nonzero partial word is output padded with zero bytes. It is followed on consecutive cycles by the length word, the first timestamp word and the second timestamp word.
- R7: The length word equals the number of payload bytes accepted since enable or abort. Padding and trailer words are not counted.
- R8: Done rises exactly DONE_DELAY cycles after the last trailer word appears. It stays high with no further output words until `en` goes low.
- R9: `running` rises in the cycle after a `start` pulse and falls in the same cycle that `done` rises.
- R10: `abort` discards any partial word and the byte count, and clears `running`. No trailer is emitted.
- R11: While `en` is low, `out_valid`, `done` and `running` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| en | input | 1 | Pixel-domain enable; low holds the pixel-domain logic in reset |
| sys_clk | input | 1 | System clock for the timestamp load |
| sys_rst_n | input | 1 | Active-low system-domain reset |
| ts_pre | input | 1 | Pulse one system cycle before the first timestamp byte |
| ts_byte | input | 8 | Timestamp byte |
| ts_copy | input | 1 | Request to copy the timestamp into the pixel domain |
| start | input | 1 | Pulse that raises the running flag |
| abort | input | 1 | Return to the accepting state without a trailer |
| flush | input | 1 | Close the frame and emit the trailer |
| cmp_data | input | DW | Compressed input word |
| cmp_bytes | input | log2(DW/8) | Valid byte count, 0 meaning all |
| cmp_valid | input | 1 | Compressed word strobe |
| raw_sel | input | 1 | Selects the raw byte path |
| raw_swap | input | 1 | Swap raw bytes in pairs |
| raw_pre | input | 1 | Pulse one cycle before four raw bytes |
| raw_byte | input | 8 | Raw byte |
| out_word | output | DW | Output word |
| out_valid | output | 1 | Output word strobe |
| running | output | 1 | Frame in progress |
| done | output | 1 | Trailer fully emitted |

## Verification
A compressed word that completes an output word is due at the first sampling point after the edge that takes it. A raw word is due one sampling point after that, because the group collector adds a register stage. The bench drives on the falling edge and reads on the next falling edge, so each latency is checked at a fixed offset from the stimulus. Every output word is logged with the count of rising edges before it. From that log the bench checks that the trailer words occupy consecutive cycles, and that done rises exactly DONE_DELAY edges after the last trailer word. The timestamp crossing has no fixed latency, so for it the bench checks only the values in the trailer and waits generously before each flush.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
   typedef enum logic [2:0] {
      ST_RUN,
      ST_HOLD,
      ST_PAD,
      ST_LEN,
      ST_TSH,
      ST_TSL,
      ST_WAIT,
      ST_DONE
   } fwp_state_t;
endpackage

// File: rtl/fwp_ts_source.sv
module fwp_ts_source #(
   parameter int TS_W = 64
) (
   input  logic            sys_clk,
   input  logic            sys_rst_n,
   input  logic            pre,
   input  logic [7:0]      byte_in,
   input  logic            req_tgl,
   output logic [TS_W-1:0] ts_hold,
   output logic            ack_tgl
);
   localparam int TB = TS_W / 8;
   localparam int BW = $clog2(TB + 1);

   logic [TS_W-1:0] shreg;
   logic [BW-1:0]   bcnt;
   logic            rq1, rq2;

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         shreg   <= '0;
         bcnt    <= '0;
         rq1     <= 1'b0;
         rq2     <= 1'b0;
         ts_hold <= '0;
         ack_tgl <= 1'b0;
      end else begin
         rq1 <= req_tgl;
         rq2 <= rq1;
         if (bcnt != '0) begin
            shreg <= {shreg[TS_W-9:0], byte_in};
            bcnt  <= (bcnt == BW'(TB)) ? '0 : bcnt + 1'b1;
         end else if (pre) begin
            bcnt <= BW'(1);
         end
         if (rq2 != ack_tgl) begin
            ts_hold <= shreg;
            ack_tgl <= rq2;
         end
      end
   end
endmodule

// File: rtl/fwp_raw_collector.sv
module fwp_raw_collector #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clear,
   input  logic          pre,
   input  logic [7:0]    byte_in,
   input  logic          swap,
   output logic [DW-1:0] word_o,
   output logic          stb_o
);
   localparam int NB = DW / 8;
   localparam int CW = $clog2(NB);

   logic [CW:0]   cnt;
   logic [CW-1:0] idx, slot;
   logic [DW-1:0] buf_q, buf_n;
   logic          take;

   assign take = (cnt != '0);
   assign idx  = CW'(cnt - 1'b1);
   assign slot = swap ? (idx ^ CW'(1)) : idx;

   for (genvar g = 0; g < NB; g++) begin : g_slot
      assign buf_n[DW-1-8*g -: 8] = (take && slot == CW'(g)) ? byte_in
                                                             : buf_q[DW-1-8*g -: 8];
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt    <= '0;
         buf_q  <= '0;
         word_o <= '0;
         stb_o  <= 1'b0;
      end else begin
         buf_q <= buf_n;
         stb_o <= (cnt == (CW+1)'(NB));
         if (cnt == (CW+1)'(NB)) word_o <= buf_n;
         if (take && cnt != (CW+1)'(NB)) cnt <= cnt + 1'b1;
         else                            cnt <= pre ? (CW+1)'(1) : '0;
      end
   end
endmodule

// File: rtl/fwp_byte_packer.sv
module fwp_byte_packer #(
   parameter int DW = 32
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          clear,
   input  logic [DW-1:0]                 in_word,
   input  logic [$clog2(DW/8)-1:0]       in_cnt,
   input  logic                          in_stb,
   output logic [DW-1:0]                 emit_word,
   output logic                          emit_stb,
   output logic [DW-1:0]                 part_word,
   output logic [$clog2(DW/4)-1:0]       fill_o,
   output logic [$clog2(DW/4)-1:0]       nb_o
);
   localparam int NB = DW / 8;
   localparam int FW = $clog2(2 * NB);

   logic [2*DW-1:0] acc, merged;
   logic [FW-1:0]   fill, nb, total;
   logic [DW-1:0]   masked;

   always_comb begin
      nb     = (in_cnt == '0) ? FW'(NB) : FW'(in_cnt);
      masked = in_word & ~({DW{1'b1}} >> (int'(nb) * 8));
      merged = acc | ({masked, {DW{1'b0}}} >> (int'(fill) * 8));
      total  = fill + nb;
   end

   assign emit_stb  = in_stb && (total >= FW'(NB));
   assign emit_word = merged[2*DW-1:DW];
   assign part_word = acc[2*DW-1:DW];
   assign fill_o    = fill;
   assign nb_o      = nb;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         acc  <= '0;
         fill <= '0;
      end else if (in_stb) begin
         if (total >= FW'(NB)) begin
            acc  <= merged << DW;
            fill <= total - FW'(NB);
         end else begin
            acc  <= merged;
            fill <= total;
         end
      end
   end
endmodule

// File: rtl/frame_word_packer.sv
module frame_word_packer #(
   parameter int DW         = 32,
   parameter int DONE_DELAY = 4
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic                    sys_clk,
   input  logic                    sys_rst_n,
   input  logic                    ts_pre,
   input  logic [7:0]              ts_byte,
   input  logic                    ts_copy,
   input  logic                    start,
   input  logic                    abort,
   input  logic                    flush,
   input  logic [DW-1:0]           cmp_data,
   input  logic [$clog2(DW/8)-1:0] cmp_bytes,
   input  logic                    cmp_valid,
   input  logic                    raw_sel,
   input  logic                    raw_swap,
   input  logic                    raw_pre,
   input  logic [7:0]              raw_byte,
   output logic [DW-1:0]           out_word,
   output logic                    out_valid,
   output logic                    running,
   output logic                    done
);
   import fwp_pkg::*;

   localparam int NB    = DW / 8;
   localparam int CW    = $clog2(NB);
   localparam int FW    = $clog2(2 * NB);
   localparam int TS_W  = 2 * DW;
   localparam int DLY_W = $clog2(DONE_DELAY + 1);

   if (DW < 16 || DW % 16 != 0) begin : g_bad_width
      $error("frame_word_packer: DW must be a positive multiple of 16");
   end
   if (DONE_DELAY < 1) begin : g_bad_delay
      $error("frame_word_packer: DONE_DELAY must be at least 1");
   end

   logic            rst;
   fwp_state_t      state;
   logic [DW-1:0]   len;
   logic [DLY_W-1:0] dly;

   logic            req_tgl, ack_tgl, ack_s1, ack_s2, ack_d, pending;
   logic [TS_W-1:0] ts_hold, ts_pix;

   logic [DW-1:0]   raw_word;
   logic            raw_stb;
   logic            accepting, pk_stb, pk_emit;
   logic [DW-1:0]   pk_in, pk_word, pk_part;
   logic [CW-1:0]   pk_cnt;
   logic [FW-1:0]   pk_fill, pk_nb;

   assign rst       = ~en;
   assign pending   = (req_tgl != ack_d);
   assign accepting = (state == ST_RUN || state == ST_HOLD) && !abort;
   assign pk_in     = raw_sel ? raw_word : cmp_data;
   assign pk_cnt    = raw_sel ? '0 : cmp_bytes;
   assign pk_stb    = accepting && (raw_sel ? raw_stb : cmp_valid);

   fwp_ts_source #(.TS_W(TS_W)) u_ts (
      .sys_clk  (sys_clk),
      .sys_rst_n(sys_rst_n),
      .pre      (ts_pre),
      .byte_in  (ts_byte),
      .req_tgl  (req_tgl),
      .ts_hold  (ts_hold),
      .ack_tgl  (ack_tgl)
   );

   fwp_raw_collector #(.DW(DW)) u_raw (
      .clk    (clk),
      .rst    (rst),
      .clear  (abort),
      .pre    (raw_pre),
      .byte_in(raw_byte),
      .swap   (raw_swap),
      .word_o (raw_word),
      .stb_o  (raw_stb)
   );

   fwp_byte_packer #(.DW(DW)) u_pack (
      .clk      (clk),
      .rst      (rst),
      .clear    (abort || state == ST_PAD),
      .in_word  (pk_in),
      .in_cnt   (pk_cnt),
      .in_stb   (pk_stb),
      .emit_word(pk_word),
      .emit_stb (pk_emit),
      .part_word(pk_part),
      .fill_o   (pk_fill),
      .nb_o     (pk_nb)
   );

   // timestamp crossing, pixel side
   always_ff @(posedge clk) begin
      if (rst) begin
         req_tgl <= 1'b0;
         ack_s1  <= 1'b0;
         ack_s2  <= 1'b0;
         ack_d   <= 1'b0;
         ts_pix  <= '0;
      end else begin
         ack_s1 <= ack_tgl;
         ack_s2 <= ack_s1;
         ack_d  <= ack_s2;
         if (ack_s2 != ack_d) ts_pix <= ts_hold;
         if (ts_copy && !pending) req_tgl <= ~req_tgl;
      end
   end

   // frame sequencer and output register
   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_RUN;
         len       <= '0;
         dly       <= '0;
         out_word  <= '0;
         out_valid <= 1'b0;
         running   <= 1'b0;
         done      <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (abort) begin
            state   <= ST_RUN;
            len     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
         end else begin
            if (pk_stb) len <= len + DW'(pk_nb);
            if (pk_emit) begin
               out_word  <= pk_word;
               out_valid <= 1'b1;
            end
            unique case (state)
               ST_RUN: begin
                  if (start) running <= 1'b1;
                  if (flush) state <= ST_HOLD;
               end
               ST_HOLD: if (!pending) state <= ST_PAD;
               ST_PAD: begin
                  if (pk_fill != '0) begin
                     out_word  <= pk_part;
                     out_valid <= 1'b1;
                  end
                  state <= ST_LEN;
               end
               ST_LEN: begin
                  out_word  <= len;
                  out_valid <= 1'b1;
                  state     <= ST_TSH;
               end
               ST_TSH: begin
                  out_word  <= ts_pix[TS_W-1:DW];
                  out_valid <= 1'b1;
                  state     <= ST_TSL;
               end
               ST_TSL: begin
                  out_word  <= ts_pix[DW-1:0];
                  out_valid <= 1'b1;
                  dly       <= '0;
                  state     <= ST_WAIT;
               end
               ST_WAIT: begin
                  if (dly == DLY_W'(DONE_DELAY - 1)) begin
                     done    <= 1'b1;
                     running <= 1'b0;
                     state   <= ST_DONE;
                  end else begin
                     dly <= dly + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fwp_checks.sv
module fwp_checks #(
   parameter int NB = 4
) (
   input logic                      clk,
   input logic                      en,
   input logic                      abort,
   input logic                      out_valid,
   input logic                      running,
   input logic                      done,
   input logic [$clog2(2*NB)-1:0]   fill
);
   localparam int FW = $clog2(2 * NB);

   // R1: the packer never keeps a whole word in reserve
   a_r1_fill_below_word: assert property (@(posedge clk) disable iff (!en)
      fill < FW'(NB));

   // R8: done stays until disable or abort
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!en)
      (done && !abort) |=> done);

   // R8: no words once the frame is closed
   a_r8_quiet_when_done: assert property (@(posedge clk) disable iff (!en)
      done |-> !out_valid);

   // R9: running is low whenever done is high
   a_r9_not_running_done: assert property (@(posedge clk) disable iff (!en)
      done |-> !running);

   // R10: abort leaves no output, no done and no running
   a_r10_abort_clean: assert property (@(posedge clk) disable iff (!en)
      abort |=> (!out_valid && !running && !done));
endmodule

bind frame_word_packer fwp_checks #(.NB(NB)) u_checks (
   .clk      (clk),
   .en       (en),
   .abort    (abort),
   .out_valid(out_valid),
   .running  (running),
   .done     (done),
   .fill     (pk_fill)
);

// File: tb/frame_word_packer_test.sv
`timescale 1ns/1ps
module frame_word_packer_test;
   localparam int DLY = 4;

   logic clk = 1'b0, sys_clk = 1'b0;
   logic en = 1'b0, sys_rst_n = 1'b0;
   logic ts_pre = 1'b0, ts_copy = 1'b0, start = 1'b0, abort = 1'b0, flush = 1'b0;
   logic [7:0] ts_byte = '0, raw_byte = '0;
   logic [31:0] cmp_data = '0;
   logic [1:0] cmp_bytes = '0;
   logic cmp_valid = 1'b0, raw_sel = 1'b0, raw_swap = 1'b0, raw_pre = 1'b0;
   logic [31:0] out_word;
   logic out_valid, running, done;

   always #4 clk = ~clk;
   always #5 sys_clk = ~sys_clk;

   frame_word_packer #(.DW(32), .DONE_DELAY(DLY)) uut (
      .clk(clk), .en(en), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
      .ts_pre(ts_pre), .ts_byte(ts_byte), .ts_copy(ts_copy), .start(start),
      .abort(abort), .flush(flush), .cmp_data(cmp_data), .cmp_bytes(cmp_bytes),
      .cmp_valid(cmp_valid), .raw_sel(raw_sel), .raw_swap(raw_swap),
      .raw_pre(raw_pre), .raw_byte(raw_byte), .out_word(out_word),
      .out_valid(out_valid), .running(running), .done(done));

   int n_chk = 0, n_fail = 0;
   int cyc = 0, done_cyc = -1;
   logic done_q = 1'b0;
   logic [31:0] got_w[$];
   int got_c[$];
   logic [31:0] exp_q[$];
   bit finished = 0;

   always @(posedge clk) cyc++;
   always @(negedge clk) begin
      if (out_valid) begin
         got_w.push_back(out_word);
         got_c.push_back(cyc);
      end
      if (done && !done_q) done_cyc = cyc;
      done_q = done;
   end

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic enable_fresh();
      @(negedge clk) en = 1'b0;
      repeat (10) @(negedge clk);
      chk(!out_valid && !done && !running, "R11 reset state",
          {out_valid, done, running}, 0);
      en = 1'b1;
      got_w.delete(); got_c.delete(); done_cyc = -1;
      @(negedge clk);
   endtask

   task automatic load_ts(logic [63:0] v);
      @(negedge sys_clk) ts_pre = 1'b1;
      @(negedge sys_clk) ts_pre = 1'b0;
      for (int i = 0; i < 8; i++) begin
         ts_byte = v[63-8*i -: 8];
         @(negedge sys_clk);
      end
      ts_byte = '0;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(running, "R9 running after start", running, 1);
   endtask

   task automatic pulse_copy();
      ts_copy = 1'b1; @(negedge clk); ts_copy = 1'b0;
   endtask

   task automatic push(logic [31:0] w, logic [1:0] c);
      cmp_data = w; cmp_bytes = c; cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
   endtask

   task automatic raw_group(logic [31:0] v, logic sw, bit check_lat);
      raw_swap = sw; raw_pre = 1'b1;
      @(negedge clk) raw_pre = 1'b0;
      for (int i = 0; i < 4; i++) begin
         raw_byte = v[31-8*i -: 8];
         @(negedge clk);
      end
      raw_byte = '0;
      if (check_lat) begin
         chk(!out_valid, "R2 raw word not yet out", out_valid, 0);
         @(negedge clk);
         chk(out_valid, "R2 raw word one cycle later", out_valid, 1);
      end
   endtask

   task automatic flush_run(bit immediate);
      flush = 1'b1; @(negedge clk); flush = 1'b0;
      repeat (immediate ? 60 : 30) @(negedge clk);
   endtask

   task automatic cmp_stream(string tag);
      chk(got_w.size() == exp_q.size(), {tag, " word count"}, got_w.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_w.size(); i++)
         chk(got_w[i] == exp_q[i], tag, got_w[i], exp_q[i]);
   endtask

   task automatic trailer_timing(int words, string tag);
      int n;
      n = got_c.size();
      if (n >= words) begin
         chk(got_c[n-1] - got_c[n-words] == words - 1, {tag, " R6 consecutive trailer"},
             got_c[n-1] - got_c[n-words], words - 1);
         chk(done_cyc - got_c[n-1] == DLY, {tag, " R8 done delay"},
             done_cyc - got_c[n-1], DLY);
      end else begin
         chk(0, {tag, " R6 too few words"}, n, words);
      end
      chk(done && !running, {tag, " R9 running falls with done"}, {done, running}, 2'b10);
      repeat (10) @(negedge clk);
      chk(done && got_w.size() == n, {tag, " R8 done holds, no more words"}, got_w.size(), n);
   endtask

   task automatic test_compressed();
      enable_fresh();
      raw_sel = 1'b0;
      pulse_start();
      load_ts(64'h0102_0304_0506_0700);
      pulse_copy();
      repeat (20) @(negedge clk);
      push(32'hAABBCCDD, 2'd0);
      chk(out_valid && out_word == 32'hAABBCCDD, "R1 full word next cycle", out_word, 32'hAABBCCDD);
      push(32'h11223344, 2'd2);
      push(32'h55667788, 2'd3);
      push(32'h99EEEEEE, 2'd1);
      flush_run(0);
      exp_q = {32'hAABBCCDD, 32'h11225566, 32'h77990000, 32'd10,
               32'h01020304, 32'h05060700};
      cmp_stream("R1 R4 R6 R7 compressed stream");
      trailer_timing(4, "compressed");
   endtask

   task automatic test_raw();
      enable_fresh();
      raw_sel = 1'b1;
      pulse_start();
      load_ts(64'hA1A2_A3A4_B1B2_B300);
      raw_group(32'h01020304, 1'b0, 1);
      raw_group(32'h05060708, 1'b1, 0);
      repeat (3) @(negedge clk);
      pulse_copy();
      flush_run(1);
      exp_q = {32'h01020304, 32'h06050807, 32'd8, 32'hA1A2A3A4, 32'hB1B2B300};
      cmp_stream("R2 R3 R5 raw stream");
      trailer_timing(3, "raw");
      raw_sel = 1'b0; raw_swap = 1'b0;
   endtask

   task automatic test_abort_hold();
      enable_fresh();
      pulse_start();
      load_ts(64'hC0C1_C2C3_C4C5_C600);
      pulse_copy();
      repeat (25) @(negedge clk);
      push(32'h12345678, 2'd3);
      abort = 1'b1; @(negedge clk); abort = 1'b0;
      repeat (15) @(negedge clk);
      chk(got_w.size() == 0, "R10 no output after abort", got_w.size(), 0);
      chk(!running && !done, "R10 flags clear after abort", {running, done}, 0);
      load_ts(64'hD0D1_D2D3_D4D5_D600);
      push(32'hCAFEF00D, 2'd2);
      flush_run(0);
      exp_q = {32'hCAFE0000, 32'd2, 32'hC0C1C2C3, 32'hC4C5C600};
      cmp_stream("R5 R7 R10 after abort");
   endtask

   initial begin
      repeat (3) @(negedge sys_clk);
      sys_rst_n = 1'b1;
      test_compressed();
      test_raw();
      test_abort_hold();
      @(negedge clk) en = 1'b0;
      @(negedge clk);
      chk(!done && !running && !out_valid, "R11 cleared by disable", {done, running, out_valid}, 0);
      summary();
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end
endmodule